// File: doc/BRIEF.md
# Counting Decimator for a One-Bit Modulator Stream

This block turns the one-bit stream of a first-order delta-sigma modulator into parallel words. It counts, over a fixed window of clock cycles, how many samples were a one. When the window closes, the finished count is copied into an output register and a one-cycle strobe is raised. The counter is cleared on the next cycle. The result is a first-order sinc (boxcar) decimation of the stream.

The modulator delivers each sample on two wires: the bit and its complement. A sample counts as a one only when the pair reads bit high and complement low. The counter saturates at its all-ones value and never wraps. A window with more ones than the word can hold therefore reports full scale, not a small number. The window length and the word width are parameters. By default a window is 500 cycles and the word is 10 bits.

Top module: `bitcount_decimator`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the output word to 0, drops the strobe and restarts the window. The first window after reset covers the first WIN_LEN samples taken while `rst` is low.
- R2: `res_valid` is high for exactly one cycle per window. It rises after the rising edge that takes the last sample of a window, which is WIN_LEN edges after the window's first sample. Windows follow each other with no gap.
- R3: When the count is already 2^ACC_W-1 (1023 for 10 bits), further one-samples leave it at that value, so the reported word is the number of ones clamped at 1023.
- R4: A sample counts as a one only when `{mod_bit, mod_bit_n}` is 2'b10. The word reported for a window equals the number of such samples in that window (clamped per R3).
- R5: `res_word` changes only in the cycle where `res_valid` is high, and holds its value for the rest of the window.
- R6: Closing a window takes two steps on successive edges: first the output register captures the finished count, then the counter is reloaded. The reload value is the count of the sample taken in that cycle (0 or 1), so the first and last samples of every window are each counted in their own window.
- R7: The pairs 2'b11 and 2'b00 on `{mod_bit, mod_bit_n}` count as zero and leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator sample clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit |
| mod_bit_n | input | 1 | Complement of the modulator output bit |
| res_word | output | ACC_W | Count of one-samples in the last complete window |
| res_valid | output | 1 | One-cycle strobe marking a newly loaded `res_word` |

## Verification
The bench builds the block with a window of 1100 cycles and the default 10-bit word. With this window a window can hold more ones than 1023, so dense patterns drive the counter into saturation and sparse ones stay below it. The same window length also shows that the strobe period follows the parameter and not the default of 500. Single-one windows, with the one at the first or the last position, expose any sample lost or double-counted at the capture-then-clear boundary. A reset in the middle of a window shows that counting restarts cleanly.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Pair encoding {bit, complement} that counts as a one-sample.
  localparam logic [1:0] PAIR_ONE = 2'b10;

  // A sample is a one only when the pair is consistent and high.
  function automatic logic pair_is_one(logic b, logic b_n);
    return ({b, b_n} == PAIR_ONE);
  endfunction

  // Width of a counter that must hold 0 .. n-1.
  function automatic int unsigned ctr_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sdd_win_timer.sv
module sdd_win_timer #(
  parameter int unsigned WIN_LEN = 500
) (
  input  logic clk,
  input  logic rst,
  output logic latch_evt,
  output logic clear_evt
);
  localparam int unsigned CW = sdd_pkg::ctr_width(WIN_LEN);
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0] phase_q;

  // Window ends on the cycle carrying the last sample.
  assign latch_evt = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      clear_evt <= 1'b0;
    end else begin
      phase_q   <= latch_evt ? '0 : phase_q + 1'b1;
      clear_evt <= latch_evt;
    end
  end
endmodule

// File: rtl/sdd_sat_accum.sv
module sdd_sat_accum #(
  parameter int unsigned ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_one,
  input  logic             clear_evt,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_next
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  // Saturating increment: full scale is sticky.
  function automatic logic [ACC_W-1:0] sat_step(logic [ACC_W-1:0] a, logic inc);
    if (a == ACC_MAX) return a;
    return a + ACC_W'(inc);
  endfunction

  always_comb begin
    if (clear_evt) acc_next = ACC_W'(sample_one);
    else           acc_next = sat_step(acc_q, sample_one);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_next;
  end
endmodule

// File: rtl/sdd_result_reg.sv
module sdd_result_reg #(
  parameter int unsigned ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_evt,
  input  logic [ACC_W-1:0] count_in,
  output logic [ACC_W-1:0] res_word,
  output logic             res_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_word  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= latch_evt;
      if (latch_evt) res_word <= count_in;
    end
  end
endmodule

// File: rtl/bitcount_decimator.sv
module bitcount_decimator #(
  parameter int unsigned WIN_LEN = 500,
  parameter int unsigned ACC_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_bit,
  input  logic             mod_bit_n,
  output logic [ACC_W-1:0] res_word,
  output logic             res_valid
);
  logic             sample_one;
  logic             latch_evt;
  logic             clear_evt;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  assign sample_one = sdd_pkg::pair_is_one(mod_bit, mod_bit_n);

  sdd_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .latch_evt (latch_evt),
    .clear_evt (clear_evt)
  );

  sdd_sat_accum #(.ACC_W(ACC_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .sample_one (sample_one),
    .clear_evt  (clear_evt),
    .acc_q      (acc_q),
    .acc_next   (acc_next)
  );

  sdd_result_reg #(.ACC_W(ACC_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .latch_evt (latch_evt),
    .count_in  (acc_next),
    .res_word  (res_word),
    .res_valid (res_valid)
  );
endmodule

// File: rtl/sdd_decim_chk.sv
module sdd_decim_chk #(
  parameter int unsigned WIN_LEN = 500,
  parameter int unsigned ACC_W   = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mod_bit,
  input logic             mod_bit_n,
  input logic             latch_evt,
  input logic             clear_evt,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] res_word,
  input logic             res_valid
);
  localparam int unsigned SW = $clog2(WIN_LEN + 1) + 1;
  localparam logic [SW-1:0] SPAN = SW'(WIN_LEN);
  localparam logic [ACC_W-1:0] FULL = '1;

  // Edges since reset or since the last strobe cycle.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)            since_q <= '0;
    else if (res_valid) since_q <= SW'(1);
    else if (since_q != SPAN) since_q <= since_q + 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && res_word == '0));

  p_strobe_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> since_q == SPAN);

  p_strobe_due_r2: assert property (@(posedge clk) disable iff (rst)
    since_q == SPAN |-> res_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_q == FULL && !clear_evt) |=> acc_q == FULL);

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mod_bit && !mod_bit_n && !clear_evt && acc_q != FULL) |=> acc_q == $past(acc_q) + 1'b1);

  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_word));

  p_clear_follows_latch_r6: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> clear_evt);

  p_clear_loads_sample_r6: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> acc_q == ACC_W'($past(mod_bit && !mod_bit_n)));

  p_invalid_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (mod_bit == mod_bit_n && !clear_evt) |=> acc_q == $past(acc_q));
endmodule

bind bitcount_decimator sdd_decim_chk #(.WIN_LEN(WIN_LEN), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mod_bit   (mod_bit),
  .mod_bit_n (mod_bit_n),
  .latch_evt (latch_evt),
  .clear_evt (clear_evt),
  .acc_q     (acc_q),
  .res_word  (res_word),
  .res_valid (res_valid)
);

// File: tb/tb_bitcount_decimator.sv
module tb_bitcount_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 1100;
  localparam int W    = 10;
  localparam int MAXV = (1 << W) - 1;

  typedef struct packed {
    logic [31:0] per;   // pattern period
    logic [31:0] hi;    // ones per period
    logic [31:0] off;   // phase offset
    logic [1:0]  mode;  // 0 clean pairs, 1 odd ones as 2'b11, 2 zeros as 2'b00
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{32'd1,    32'd0,  32'd0, 2'd0},  // R4 all zero
    '{32'd2,    32'd1,  32'd0, 2'd0},  // R4 half density
    '{32'd4,    32'd1,  32'd0, 2'd0},  // R4 quarter density
    '{32'd10,   32'd9,  32'd0, 2'd0},  // R4 just under full scale
    '{32'd100,  32'd95, 32'd0, 2'd0},  // R3 over full scale
    '{32'd1,    32'd1,  32'd0, 2'd0},  // R3 all ones
    '{32'd1100, 32'd1,  32'd0, 2'd0},  // R6 first sample only
    '{32'd1100, 32'd1,  32'd1, 2'd0},  // R6 last sample only
    '{32'd3,    32'd2,  32'd0, 2'd1},  // R7 some ones as 2'b11
    '{32'd2,    32'd1,  32'd1, 2'd2},  // R7 zeros as 2'b00
    '{32'd7,    32'd3,  32'd2, 2'd0}   // R4 odd period
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_bit = 1'b0;
  logic mod_bit_n = 1'b1;
  logic [W-1:0] res_word;
  logic res_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int last_word = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitcount_decimator #(.WIN_LEN(WIN), .ACC_W(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .mod_bit   (mod_bit),
    .mod_bit_n (mod_bit_n),
    .res_word  (res_word),
    .res_valid (res_valid)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] pair_for(vec_t v, int i);
    logic b;
    b = ((i + int'(v.off)) % int'(v.per)) < int'(v.hi);
    case (v.mode)
      2'd1:    return b ? ((i % 2 == 1) ? 2'b11 : 2'b10) : 2'b01;
      2'd2:    return b ? 2'b10 : 2'b00;
      default: return b ? 2'b10 : 2'b01;
    endcase
  endfunction

  // Entered just after a falling edge; leaves just after a falling edge.
  task automatic run_window(vec_t v, string tag);
    int exp_cnt = 0;
    int bad_strobe = 0;
    int bad_hold = 0;
    for (int i = 0; i < WIN; i++) begin
      logic [1:0] pr;
      pr = pair_for(v, i);
      {mod_bit, mod_bit_n} = pr;
      if (pr == 2'b10) exp_cnt++;
      @(posedge clk);
      @(negedge clk);
      if (i < WIN - 1) begin
        if (res_valid !== 1'b0) bad_strobe++;
        if (int'(res_word) != last_word) bad_hold++;
      end
    end
    if (exp_cnt > MAXV) exp_cnt = MAXV;
    check(tag, int'(res_word), exp_cnt);
    check("R2 strobe at window end", int'(res_valid), 1);
    check("R2 no early strobe", bad_strobe, 0);
    check("R5 word held inside window", bad_hold, 0);
    last_word = exp_cnt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", int'(res_word), 0);
    check("R1 reset strobe", int'(res_valid), 0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      string tag;
      if (VECS[k].mode != 2'd0) tag = "R7 invalid pairs";
      else if (k == 6 || k == 7) tag = "R6 boundary sample";
      else if (k == 4 || k == 5) tag = "R3 saturation";
      else tag = "R4 count";
      run_window(VECS[k], tag);
    end

    // R1: reset in the middle of a window, then a clean restart
    for (int i = 0; i < 300; i++) begin
      {mod_bit, mod_bit_n} = 2'b10;
      @(posedge clk);
      @(negedge clk);
    end
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-window reset word", int'(res_word), 0);
    check("R1 mid-window reset strobe", int'(res_valid), 0);
    rst = 1'b0;
    last_word = 0;
    run_window(VECS[1], "R1 restart count");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule